// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block checks that a scan chain shifts correctly before any pattern work on the logic around it begins. A single pulse on `start_i` starts a run. The block then holds the chain in shift mode and drives a short toggle stimulus into the chain's serial input. It watches the serial output for the same stimulus, delayed by the chain length, and reports a verdict.

The stimulus is `CHAIN_LEN + 4` bits long. Its first four bits are 0, 0, 1, 1, and every bit after them is 0. As the stimulus passes through, each cell holds a 0 for two cycles and a 1 for two cycles, and sees one rising and one falling transition. The block keeps a private copy of the driven bits in a delay line of the same length as the chain, which gives the expected output for each cycle.

Any mismatch inside the comparison window latches a fail flag. At the end of the run, pass is raised together with done only if no mismatch was seen. The block does not say which cell failed.

Top module: `scan_flush_tester`

## Requirements
- R1: While reset is held, busy, done, pass, fail and scan_in are all 0 and func_sel is 1 (functional capture).
- R2: A start seen high at a clock edge while no run is active makes busy 1 from the next cycle for exactly CHAIN_LEN+4 cycles. Done rises in the cycle after the last busy cycle.
- R3: func_sel is 0 (shift) in every busy cycle and 1 in every cycle that is not busy.
- R4: In run cycle k (k = 0 at the first busy cycle), scan_in is 1 for k = 2 and k = 3 and 0 for every other k. Outside a run, scan_in is 0.
- R5: Only run cycles k >= CHAIN_LEN are compared. In such a cycle the expected scan_out equals the scan_in bit driven in cycle k - CHAIN_LEN. Any scan_out value in cycles k < CHAIN_LEN has no effect on the verdict.
- R6: A compared mismatch sets fail, visible from the next cycle. Fail then stays 1 until the next accepted start.
- R7: Pass is 1 only while done is 1 and fail is 0. Pass and fail are never both 1.
- R8: A start seen while busy is ignored, and the run keeps its original length and stimulus.
- R9: Done, pass and fail hold their values while idle. An accepted start clears done and fail from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-stage synchroniser |
| start_i | input | 1 | Run request, sampled at the clock edge |
| scan_out_i | input | 1 | Serial output of the last cell in the chain |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished; verdict valid |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_o | output | 1 | Sticky mismatch flag |
| scan_in_o | output | 1 | Serial stimulus for the first cell in the chain |
| func_sel_o | output | 1 | Cell mode select: 0 = shift, 1 = functional capture |

## Verification
Each result has a fixed due time, counted from the clock edge that accepts start. That edge is followed by busy, and by run cycle k = 0 of the stimulus, in the next cycle. A mismatch at run cycle k shows on fail in cycle k + 1. Done and the pass/fail verdict are due in cycle CHAIN_LEN + 4, one cycle after the last busy cycle. The bench drives start on a falling edge and samples every output on falling edges. It checks busy, func_sel and scan_in in each run cycle against its own index of that cycle, and checks the verdict only at the cycle where it is due.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;
  typedef enum logic [1:0] {
    SF_IDLE = 2'd0,
    SF_RUN  = 2'd1,
    SF_DONE = 2'd2
  } sf_state_e;

  // Toggle core, bit 0 driven first: 0,0,1,1
  localparam int unsigned    CORE_LEN     = 4;
  localparam int unsigned    CORE_IW      = $clog2(CORE_LEN);
  localparam logic [CORE_LEN-1:0] CORE_PATTERN = 4'b1100;
  // Flush bit after the core; must be 0 so the 1,1 pair ends on a fall
  localparam logic           PAD_BIT      = 1'b0;
endpackage

// File: rtl/sf_reset_sync.sv
module sf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/sf_sequencer.sv
module sf_sequencer
  import scan_flush_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              launch_o,
  output logic              finish_o,
  output logic              cmp_en_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int unsigned     TOTAL     = CHAIN_LEN + CORE_LEN;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);
  localparam logic [STEP_W-1:0] WIN_START = STEP_W'(CHAIN_LEN);

  sf_state_e         state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              running;
  logic              at_last;

  assign running  = (state_q == SF_RUN);
  assign at_last  = (step_q == LAST_STEP);
  assign launch_o = start_i && !running;

  // next-state process
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      SF_IDLE, SF_DONE: begin
        if (start_i) begin
          state_d = SF_RUN;
          step_d  = '0;
        end
      end
      SF_RUN: begin
        if (at_last) begin
          state_d = SF_DONE;
          step_d  = '0;
        end else begin
          step_d  = step_q + 1'b1;
        end
      end
      default: begin
        state_d = SF_IDLE;
        step_d  = '0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SF_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy_o   = running;
  assign finish_o = running && at_last;
  assign cmp_en_o = running && (step_q >= WIN_START);
  assign step_o   = step_q;
endmodule

// File: rtl/sf_pattern.sv
module sf_pattern
  import scan_flush_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic              active_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              bit_o
);
  localparam logic [STEP_W-1:0] CORE_END = STEP_W'(CORE_LEN);

  logic in_core;
  logic core_bit;

  assign in_core  = (step_i < CORE_END);
  assign core_bit = CORE_PATTERN[step_i[CORE_IW-1:0]];

  always_comb begin
    if (!active_i) begin
      bit_o = 1'b0;
    end else if (in_core) begin
      bit_o = core_bit;
    end else begin
      bit_o = PAD_BIT;
    end
  end
endmodule

// File: rtl/sf_ref_delay.sv
module sf_ref_delay #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en_i,
  input  logic din_i,
  output logic dout_o
);
  logic [DEPTH-1:0] stage_q, stage_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_d[g] = din_i;
    end else begin : g_body
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (shift_en_i) begin
      stage_q <= stage_d;
    end
  end

  assign dout_o = stage_q[DEPTH-1];
endmodule

// File: rtl/sf_verdict.sv
module sf_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic finish_i,
  input  logic cmp_en_i,
  input  logic observed_i,
  input  logic expected_i,
  output logic done_o,
  output logic fail_o,
  output logic pass_o
);
  logic done_q, done_d;
  logic fail_q, fail_d;
  logic mismatch;

  assign mismatch = cmp_en_i && (observed_i != expected_i);

  always_comb begin
    done_d = done_q;
    fail_d = fail_q;
    if (clear_i) begin
      done_d = 1'b0;
      fail_d = 1'b0;
    end else begin
      if (mismatch) fail_d = 1'b1;
      if (finish_i) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;
  assign pass_o = done_q && !fail_q;
endmodule

// File: rtl/scan_flush_tester.sv
module scan_flush_tester
  import scan_flush_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scan_out_i,
  output logic busy_o,
  output logic done_o,
  output logic pass_o,
  output logic fail_o,
  output logic scan_in_o,
  output logic func_sel_o
);
  localparam int unsigned STEP_W = $clog2(CHAIN_LEN + CORE_LEN + 1);

  logic              rst_n_int;
  logic              busy;
  logic              launch;
  logic              finish;
  logic              cmp_en;
  logic [STEP_W-1:0] step;
  logic              drive_bit;
  logic              expect_bit;

  sf_reset_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  sf_sequencer #(
    .CHAIN_LEN (CHAIN_LEN),
    .STEP_W    (STEP_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .busy_o   (busy),
    .launch_o (launch),
    .finish_o (finish),
    .cmp_en_o (cmp_en),
    .step_o   (step)
  );

  sf_pattern #(
    .STEP_W (STEP_W)
  ) u_pat (
    .active_i (busy),
    .step_i   (step),
    .bit_o    (drive_bit)
  );

  sf_ref_delay #(
    .DEPTH (CHAIN_LEN)
  ) u_ref (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .shift_en_i (busy),
    .din_i      (drive_bit),
    .dout_o     (expect_bit)
  );

  sf_verdict u_ver (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clear_i    (launch),
    .finish_i   (finish),
    .cmp_en_i   (cmp_en),
    .observed_i (scan_out_i),
    .expected_i (expect_bit),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .pass_o     (pass_o)
  );

  assign busy_o     = busy;
  assign scan_in_o  = drive_bit;
  assign func_sel_o = !busy;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input logic scan_in_o,
  input logic func_sel_o
);
  localparam int unsigned TOTAL = CHAIN_LEN + 4;

  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!busy_o && !done_o && !pass_o && !fail_o && !scan_in_o && func_sel_o);
    end
  end

  a_r2_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o && !fail_o) |=> busy_o);

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < TOTAL));

  a_r8_run_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_cnt == TOTAL - 1) |=> (!busy_o && done_o));

  a_r3_shift_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !func_sel_o);

  a_r4_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scan_in_o);

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o)) |=> fail_o);

  a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (done_o && !fail_o));

  a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

bind scan_flush_tester sf_checker #(.CHAIN_LEN(CHAIN_LEN)) u_sf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .scan_in_o  (scan_in_o),
  .func_sel_o (func_sel_o)
);

// File: tb/scan_flush_tester_bench.sv
module scan_flush_tester_bench;
  localparam int N     = 8;
  localparam int TOTAL = N + 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, scan_out_i;
  logic busy_o, done_o, pass_o, fail_o, scan_in_o, func_sel_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  // bench model of the scan chain: up to N+1 cells, selectable tap and stuck cell
  logic [N:0] cells, cells_nxt;
  int   chain_len  = N;
  int   stuck_idx  = -1;
  logic stuck_val  = 1'b0;
  logic preload_en = 1'b0;
  logic preload_v  = 1'b0;

  always_comb begin
    cells_nxt = {cells[N-1:0], scan_in_o};
    if (stuck_idx >= 0 && stuck_idx <= N) cells_nxt[stuck_idx] = stuck_val;
  end

  always @(posedge clk) begin
    if (preload_en) cells <= {(N+1){preload_v}};
    else if (!func_sel_o) cells <= cells_nxt;
  end

  assign scan_out_i = cells[chain_len-1];

  scan_flush_tester #(.CHAIN_LEN(N)) u_scan_flush_tester (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .scan_out_i (scan_out_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .scan_in_o  (scan_in_o),
    .func_sel_o (func_sel_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
      finish_run();
    end
  end

  task automatic setup_chain(input int len, input logic pv, input int sidx, input logic sval);
    @(negedge clk);
    chain_len  = len;
    stuck_idx  = sidx;
    stuck_val  = sval;
    preload_v  = pv;
    preload_en = 1'b1;
    @(negedge clk);
    preload_en = 1'b0;
  endtask

  // one full run; pulse_at >= 0 raises start again in that run cycle (R8)
  task automatic do_run(input string name, input bit exp_pass, input int pulse_at);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      if (k == 0) begin
        check(done_o == 1'b0 && fail_o == 1'b0, {name, " R9 verdict cleared"}, int'({done_o, fail_o}), 0);
      end
      check(busy_o == 1'b1, {name, " R2 busy"}, busy_o, 1);
      check(func_sel_o == 1'b0, {name, " R3 shift mode"}, func_sel_o, 0);
      check(scan_in_o == ((k == 2 || k == 3) ? 1'b1 : 1'b0), {name, " R4 stimulus"},
            scan_in_o, (k == 2 || k == 3) ? 1 : 0);
      if (exp_pass) check(fail_o == 1'b0, {name, " R5 no early fail"}, fail_o, 0);
      if (k == pulse_at) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    check(busy_o == 1'b0 && func_sel_o == 1'b1, {name, " R2 R3 run ends"}, int'({busy_o, func_sel_o}), 1);
    check(done_o == 1'b1, {name, " R2 done"}, done_o, 1);
    check(pass_o == exp_pass, {name, " R7 pass"}, pass_o, exp_pass);
    check(fail_o == !exp_pass, {name, " R6 fail"}, fail_o, !exp_pass);
    check(!(pass_o && fail_o), {name, " R7 exclusive"}, int'({pass_o, fail_o}), 0);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    preload_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !pass_o && !fail_o, "R1 reset flags", int'({busy_o, done_o, pass_o, fail_o}), 0);
    check(func_sel_o == 1'b1 && scan_in_o == 1'b0, "R1 reset drive", int'({func_sel_o, scan_in_o}), 2);
    preload_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && scan_in_o == 1'b0, "R4 idle line low", int'({busy_o, scan_in_o}), 0);
  endtask

  task automatic t_healthy_zero();
    setup_chain(N, 1'b0, -1, 1'b0);
    do_run("healthy0", 1'b1, -1);
  endtask

  task automatic t_healthy_ones();
    // chain starts full of 1s: outputs before cycle N differ but must be ignored (R5)
    setup_chain(N, 1'b1, -1, 1'b0);
    do_run("healthy1 R5", 1'b1, -1);
  endtask

  task automatic t_stuck();
    setup_chain(N, 1'b0, 3, 1'b0);
    do_run("stuck0 R6", 1'b0, -1);
    setup_chain(N, 1'b0, 5, 1'b1);
    do_run("stuck1 R6", 1'b0, -1);
  endtask

  task automatic t_length();
    setup_chain(N + 1, 1'b0, -1, 1'b0);
    do_run("long R5", 1'b0, -1);
    setup_chain(N - 1, 1'b0, -1, 1'b0);
    do_run("short R5", 1'b0, -1);
  endtask

  task automatic t_restart_ignored();
    setup_chain(N, 1'b0, -1, 1'b0);
    do_run("restart R8", 1'b1, 5);
  endtask

  task automatic t_hold_and_clear();
    setup_chain(N, 1'b0, 2, 1'b1);
    do_run("hold R9", 1'b0, -1);
    repeat (5) @(negedge clk);
    check(done_o && fail_o && !pass_o, "R9 verdict held", int'({done_o, fail_o, pass_o}), 6);
    check(!busy_o && !scan_in_o, "R9 idle after hold", int'({busy_o, scan_in_o}), 0);
    setup_chain(N, 1'b0, -1, 1'b0);
    do_run("clear R9", 1'b1, -1);
  endtask

  initial begin
    t_reset();
    t_healthy_zero();
    t_healthy_ones();
    t_stuck();
    t_length();
    t_restart_ignored();
    t_hold_and_clear();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule